// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit runs a multi-register memory transfer, either a load or a store, for a processor core. The caller presents a register-select mask with one bit per architectural register, a base address, one of four stepping modes, a base-update flag, a direction flag and a privileged-transfer flag, and pulses start. The sequencer counts the selected registers and works out the lowest address the group will touch. It then makes one word access per selected register over a request/acknowledge memory port, taking registers in rising index order at rising addresses.

On a load, each acknowledged word is handed to the register file with its index. The word for the highest register (the program counter) is kept aside and reported as the next fetch address. On a store, the sequencer presents the index and takes the register value straight back on a data input. When the group is finished, a one-cycle completion pulse carries the updated base value, the new program counter when one was loaded, and a request to restore the status word from its saved copy.

The register file, the memory and the status words are outside this block. It only produces the indices, addresses, strobes and values that these parts need.

Top module: `blk_xfer_seq`

## Requirements
- R1: The number of memory accesses in a transfer equals the number of set bits in `reglist_i`. `mem_req_o` stays high, with the address held, until `mem_ack_i` is sampled high.
- R2: The first access address depends on `mode_i`. Mode 0 uses the base. Mode 1 uses base+4. Mode 2 uses base−4·n+4. Mode 3 uses base−4·n. Here n is the number of set bits.
- R3: Registers are accessed from the lowest set index to the highest. Each access address is 4 above the previous one. `reg_idx_o` shows the index of the current access.
- R4: `wb_value_o` at completion is base+4·n for modes 0 and 1, and base−4·n for modes 2 and 3.
- R5: `wb_we_o` is high during the completion pulse only when the base-update flag was set and the list was non-empty.
- R6: `psr_restore_o` is high during the completion pulse only for a load with the privileged flag set and bit 15 in the list.
- R7: `reg_user_o` is high during the accesses when the privileged flag is set and the transfer is a store, or a load whose list lacks bit 15.
- R8: On a load whose list includes bit 15, the word read for index 15 is given on `pc_value_o`, with `pc_we_o` high during the completion pulse. That word is not written through `rd_we_o`.
- R9: An empty list gives a completion pulse in the cycle after start, with no memory access and `wb_we_o` low.
- R10: `done_o` is high for exactly one cycle, one cycle after the last acknowledged access, and `busy_o` is low in the next cycle.
- R11: A start pulse while `busy_o` is high is ignored. The running transfer keeps its addresses and indices and no second transfer follows.
- R12: On a store, `mem_wdata_o` equals `st_data_i` and `mem_we_o` is high. On a load, `rd_we_o` is high in the acknowledge cycle, with `rd_data_o` equal to `mem_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| reglist_i | input | 16 | Register-select mask |
| base_i | input | 32 | Base address |
| mode_i | input | 2 | Stepping mode, 0..3 as in R2 |
| wb_en_i | input | 1 | Base-update request |
| load_i | input | 1 | 1 = load, 0 = store |
| priv_i | input | 1 | Privileged-transfer flag |
| busy_o | output | 1 | Transfer in progress, including the completion cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Store data |
| mem_ack_i | input | 1 | Access acknowledge |
| mem_rdata_i | input | 32 | Load data, valid with the acknowledge |
| reg_idx_o | output | 4 | Index of the register being transferred |
| reg_user_o | output | 1 | Use the user-mode register bank |
| st_data_i | input | 32 | Register value for `reg_idx_o` (store) |
| rd_we_o | output | 1 | Register write strobe (load) |
| rd_data_o | output | 32 | Register write data (load) |
| done_o | output | 1 | One-cycle completion pulse |
| wb_we_o | output | 1 | Base register update strobe |
| wb_value_o | output | 32 | Updated base value |
| pc_we_o | output | 1 | Program counter update strobe |
| pc_value_o | output | 32 | Loaded program counter value |
| psr_restore_o | output | 1 | Copy saved status into current status |

## Verification
The first request appears in the cycle after the start edge. Each following request appears in the cycle after the previous acknowledge. The completion outputs appear in the cycle after the last acknowledge, or in the cycle after start for an empty list, and idle follows one cycle later. The bench drives every input on the falling edge and samples each output at the falling edge of the cycle in which it is due. Load strobes are combinational with the acknowledge, so they are read a moment after the bench raises the acknowledge. Acknowledge latency of zero, one and two cycles is swept over every mode, direction and flag combination, so each timing point is tested with back-to-back and stretched handshakes.

// File: rtl/blk_xfer_pkg.sv
// Package: shared types for the block transfer sequencer.
// Assumes: mode codes are fixed by the instruction encoding upstream.
package blk_xfer_pkg;

    // Stepping modes; the code values are decoded by the caller's encoder.
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } step_mode_e;

    // Sequencer phases.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/blk_xfer_addr.sv
// Module: blk_xfer_addr
// Counts the selected registers and derives the first access address and
// the final base value for the chosen stepping mode. Purely combinational.
// Assumes: WORD_BYTES is a power of two.
module blk_xfer_addr #(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic [NREG-1:0]   list_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] first_addr_o,
    output logic [ADDR_W-1:0] wb_value_o,
    output logic              nonempty_o
);
    import blk_xfer_pkg::*;

    localparam int CNT_W   = $clog2(NREG + 1);
    localparam int STEP_SH = $clog2(WORD_BYTES);

    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] step;
    step_mode_e        mode;

    // Population count of the register mask.
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CNT_W'(list_i[i]);
        end
    end

    assign span       = ADDR_W'(count) << STEP_SH;
    assign step       = ADDR_W'(WORD_BYTES);
    assign mode       = step_mode_e'(mode_i);
    assign nonempty_o = |list_i;

    // Lowest address of the group, per stepping mode.
    always_comb begin
        unique case (mode)
            AM_INC_AFTER:  first_addr_o = base_i;
            AM_INC_BEFORE: first_addr_o = base_i + step;
            AM_DEC_AFTER:  first_addr_o = base_i - span + step;
            default:       first_addr_o = base_i - span;
        endcase
    end

    // Final base value: up for incrementing modes, down for decrementing.
    always_comb begin
        if (mode_i[1]) wb_value_o = base_i - span;
        else           wb_value_o = base_i + span;
    end

endmodule

// File: rtl/blk_xfer_pick.sv
// Module: blk_xfer_pick
// Finds the lowest set bit of the remaining mask, returning its index, its
// one-hot form, and whether it is the last bit left.
// Assumes: the result is only used while the mask is non-zero.
module blk_xfer_pick #(
    parameter int NREG = 16
) (
    input  logic [NREG-1:0]         rem_i,
    output logic [$clog2(NREG)-1:0] idx_o,
    output logic [NREG-1:0]         onehot_o,
    output logic                    last_o
);
    localparam int IDX_W = $clog2(NREG);

    logic [NREG-1:0] lower_seen;

    // Prefix OR: bit i is set when any lower bit of the mask is set.
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_prefix
            if (g == 0) begin : g_first
                assign lower_seen[g] = 1'b0;
            end else begin : g_rest
                assign lower_seen[g] = lower_seen[g-1] | rem_i[g-1];
            end
            assign onehot_o[g] = rem_i[g] & ~lower_seen[g];
        end
    endgenerate

    // Encode the one-hot selection into an index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (onehot_o[i]) idx_o = IDX_W'(i);
        end
    end

    assign last_o = ~|(rem_i & ~onehot_o);

endmodule

// File: rtl/blk_xfer_seq.sv
// Module: blk_xfer_seq (top)
// Runs a multi-register load or store: one word access per selected
// register, in rising index order at rising addresses, then a one-cycle
// completion pulse with base update, loaded PC and status-restore request.
// Assumes: register file and memory are external; st_data_i follows
// reg_idx_o combinationally; no aborts.
module blk_xfer_seq #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NREG-1:0]         reglist_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic [1:0]              mode_i,
    input  logic                    wb_en_i,
    input  logic                    load_i,
    input  logic                    priv_i,
    output logic                    busy_o,
    output logic                    mem_req_o,
    output logic                    mem_we_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic [DATA_W-1:0]       mem_wdata_o,
    input  logic                    mem_ack_i,
    input  logic [DATA_W-1:0]       mem_rdata_i,
    output logic [$clog2(NREG)-1:0] reg_idx_o,
    output logic                    reg_user_o,
    input  logic [DATA_W-1:0]       st_data_i,
    output logic                    rd_we_o,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    done_o,
    output logic                    wb_we_o,
    output logic [ADDR_W-1:0]       wb_value_o,
    output logic                    pc_we_o,
    output logic [DATA_W-1:0]       pc_value_o,
    output logic                    psr_restore_o
);
    import blk_xfer_pkg::*;

    localparam int                IDX_W  = $clog2(NREG);
    localparam logic [IDX_W-1:0]  PC_IDX = IDX_W'(NREG - 1);
    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(WORD_BYTES);

    phase_e            phase_q;
    logic [NREG-1:0]   rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbval_q;
    logic [DATA_W-1:0] pc_q;
    logic              load_q;
    logic              wben_q;
    logic              user_q;
    logic              pcsel_q;
    logic              restore_q;
    logic              nonempty_q;

    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] wb_calc;
    logic              nonempty;
    logic [IDX_W-1:0]  cur_idx;
    logic [NREG-1:0]   cur_onehot;
    logic              cur_last;
    logic              accept;
    logic              beat;

    blk_xfer_addr #(
        .ADDR_W    (ADDR_W),
        .NREG      (NREG),
        .WORD_BYTES(WORD_BYTES)
    ) u_addr (
        .list_i      (reglist_i),
        .base_i      (base_i),
        .mode_i      (mode_i),
        .first_addr_o(first_addr),
        .wb_value_o  (wb_calc),
        .nonempty_o  (nonempty)
    );

    blk_xfer_pick #(
        .NREG(NREG)
    ) u_pick (
        .rem_i   (rem_q),
        .idx_o   (cur_idx),
        .onehot_o(cur_onehot),
        .last_o  (cur_last)
    );

    assign accept = start_i && (phase_q == PH_IDLE);
    assign beat   = (phase_q == PH_XFER) && mem_ack_i;

    // Phase sequencing: idle -> transfer (or straight to done) -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (accept) phase_q <= nonempty ? PH_XFER : PH_DONE;
                PH_XFER: if (mem_ack_i && cur_last) phase_q <= PH_DONE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Capture the command and precomputed addresses at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbval_q    <= '0;
            load_q     <= 1'b0;
            wben_q     <= 1'b0;
            user_q     <= 1'b0;
            pcsel_q    <= 1'b0;
            restore_q  <= 1'b0;
            nonempty_q <= 1'b0;
        end else if (accept) begin
            wbval_q    <= wb_calc;
            load_q     <= load_i;
            wben_q     <= wb_en_i;
            user_q     <= priv_i && (!load_i || !reglist_i[NREG-1]);
            pcsel_q    <= load_i && reglist_i[NREG-1];
            restore_q  <= load_i && priv_i && reglist_i[NREG-1];
            nonempty_q <= nonempty;
        end
    end

    // Remaining mask and running address, stepped on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            rem_q  <= reglist_i;
            addr_q <= first_addr;
        end else if (beat) begin
            rem_q  <= rem_q & ~cur_onehot;
            addr_q <= addr_q + STEP;
        end
    end

    // Hold the word loaded for the program counter index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (beat && load_q && (cur_idx == PC_IDX)) begin
            pc_q <= mem_rdata_i;
        end
    end

    // Memory and register-file side of each access.
    always_comb begin
        mem_req_o   = (phase_q == PH_XFER);
        mem_we_o    = mem_req_o && !load_q;
        mem_addr_o  = addr_q;
        mem_wdata_o = st_data_i;
        reg_idx_o   = cur_idx;
        reg_user_o  = mem_req_o && user_q;
        rd_we_o     = beat && load_q && (cur_idx != PC_IDX);
        rd_data_o   = mem_rdata_i;
    end

    // Completion outputs, valid in the single done cycle.
    always_comb begin
        busy_o        = (phase_q != PH_IDLE);
        done_o        = (phase_q == PH_DONE);
        wb_we_o       = done_o && wben_q && nonempty_q;
        wb_value_o    = wbval_q;
        pc_we_o       = done_o && pcsel_q;
        pc_value_o    = pc_q;
        psr_restore_o = done_o && restore_q;
    end

endmodule

// File: rtl/blk_xfer_seq_chk.sv
// Module: blk_xfer_seq_chk
// Protocol and sequencing properties for blk_xfer_seq, attached by bind.
// Assumes: reset is synchronous and active low.
module blk_xfer_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              reglist_zero,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic              mem_ack_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [IDX_W-1:0]  reg_idx_o,
    input logic              reg_user_o,
    input logic              done_o,
    input logic              wb_we_o,
    input logic              pc_we_o,
    input logic              psr_restore_o
);

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(reg_idx_o));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

    // R3
    idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i |=> !mem_req_o || (reg_idx_o > $past(reg_idx_o)));

    // R5
    wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we_o |-> done_o);

    // R6
    restore_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psr_restore_o |-> pc_we_o && done_o);

    // R7
    user_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> $stable(reg_user_o));

    // R8
    pc_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |-> done_o);

    // R9
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && reglist_zero |=> done_o && !mem_req_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
    .ADDR_W(ADDR_W),
    .IDX_W ($clog2(NREG))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .reglist_zero (~|reglist_i),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_ack_i    (mem_ack_i),
    .mem_addr_o   (mem_addr_o),
    .reg_idx_o    (reg_idx_o),
    .reg_user_o   (reg_user_o),
    .done_o       (done_o),
    .wb_we_o      (wb_we_o),
    .pc_we_o      (pc_we_o),
    .psr_restore_o(psr_restore_o)
);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reglist_i = '0;
    logic [31:0] base_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wb_en_i = 1'b0, load_i = 1'b0, priv_i = 1'b0;
    logic        busy_o, mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, st_data_i;
    logic [3:0]  reg_idx_o;
    logic        reg_user_o, rd_we_o, done_o, wb_we_o, pc_we_o, psr_restore_o;
    logic [31:0] rd_data_o, wb_value_o, pc_value_o;

    int checks = 0;
    int fails  = 0;
    bit over   = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5a5a_0000;
    endfunction

    function automatic logic [31:0] regval(input logic [3:0] i);
        return 32'h1000_0000 + 32'(i) * 32'h0011_0101;
    endfunction

    assign mem_rdata_i = memval(mem_addr_o);
    assign st_data_i   = regval(reg_idx_o);

    blk_xfer_seq u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!over) begin
            over = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    task automatic run_case(input logic [15:0] list, input logic [31:0] base,
                            input logic [1:0] mode, input bit wb, input bit ld,
                            input bit s, input int lat);
        int n = 0;
        int pos = 0;
        logic [31:0] first, addr, wbv, pcv;
        logic [3:0] idx;
        for (int i = 0; i < 16; i++) n += int'(list[i]);
        case (mode)
            2'd0: first = base;
            2'd1: first = base + 4;
            2'd2: first = base - 32'(4 * n) + 4;
            default: first = base - 32'(4 * n);
        endcase
        wbv = mode[1] ? base - 32'(4 * n) : base + 32'(4 * n);
        pcv = '0;
        @(negedge clk);
        start_i = 1; reglist_i = list; base_i = base; mode_i = mode;
        wb_en_i = wb; load_i = ld; priv_i = s;
        @(negedge clk);
        start_i = 0;
        chk(busy_o === 1'b1, "R10", "busy after start", 32'(busy_o), 1);
        addr = first;
        for (int k = 0; k < n; k++) begin
            while (!list[pos]) pos++;
            idx = 4'(pos);
            for (int w = 0; w < lat; w++) begin
                chk(mem_req_o === 1'b1, "R1", "request held", 32'(mem_req_o), 1);
                if (k == 0 && w == 0 && lat == 2) begin
                    // R11: start while busy, with different inputs
                    start_i = 1; reglist_i = ~list; base_i = base ^ 32'h0000_fff0;
                end
                @(negedge clk);
                start_i = 0; reglist_i = list; base_i = base;
            end
            chk(mem_req_o === 1'b1, "R1", "request", 32'(mem_req_o), 1);
            if (k == 0) chk(mem_addr_o === first, "R2", "first address", mem_addr_o, first);
            chk(mem_addr_o === addr, "R3", "address", mem_addr_o, addr);
            chk(reg_idx_o === idx, "R3", "index", 32'(reg_idx_o), 32'(idx));
            chk(reg_user_o === (s && (!ld || !list[15])), "R7", "user bank",
                32'(reg_user_o), 32'(s && (!ld || !list[15])));
            chk(mem_we_o === !ld, "R12", "write enable", 32'(mem_we_o), 32'(!ld));
            if (!ld) chk(mem_wdata_o === regval(idx), "R12", "store data", mem_wdata_o, regval(idx));
            mem_ack_i = 1;
            #1;
            chk(rd_we_o === (ld && idx != 4'd15), "R8", "reg write strobe",
                32'(rd_we_o), 32'(ld && idx != 4'd15));
            if (ld && idx != 4'd15)
                chk(rd_data_o === memval(addr), "R12", "load data", rd_data_o, memval(addr));
            if (idx == 4'd15) pcv = memval(addr);
            @(negedge clk);
            mem_ack_i = 0;
            addr = addr + 4;
            pos++;
        end
        if (n == 0) chk(mem_req_o === 1'b0, "R9", "no access", 32'(mem_req_o), 0);
        chk(done_o === 1'b1, n == 0 ? "R9" : "R10", "done pulse", 32'(done_o), 1);
        chk(mem_req_o === 1'b0, "R1", "no extra access", 32'(mem_req_o), 0);
        chk(wb_we_o === (wb && n != 0), "R5", "base write", 32'(wb_we_o), 32'(wb && n != 0));
        if (n != 0) chk(wb_value_o === wbv, "R4", "base value", wb_value_o, wbv);
        chk(pc_we_o === (ld && list[15]), "R8", "pc write", 32'(pc_we_o), 32'(ld && list[15]));
        if (ld && list[15]) chk(pc_value_o === pcv, "R8", "pc value", pc_value_o, pcv);
        chk(psr_restore_o === (ld && s && list[15]), "R6", "status restore",
            32'(psr_restore_o), 32'(ld && s && list[15]));
        @(negedge clk);
        chk(done_o === 1'b0, "R10", "done single cycle", 32'(done_o), 0);
        chk(busy_o === 1'b0, "R11", "idle, no restart", 32'(busy_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy_o === 1'b0, "R10", "reset busy", 32'(busy_o), 0);
        chk(mem_req_o === 1'b0, "R1", "reset request", 32'(mem_req_o), 0);
        chk(done_o === 1'b0, "R10", "reset done", 32'(done_o), 0);
        for (int j = 0; j < 20; j++) begin
            logic [15:0] list;
            case (j)
                0: list = 16'h0000;
                1: list = 16'h0001;
                2: list = 16'h8000;
                3: list = 16'hffff;
                4: list = 16'h8001;
                5: list = 16'h7ffe;
                default: list = 16'(j * 16'h9e37) ^ 16'(j << 3);
            endcase
            for (int c = 0; c < 32; c++) begin
                run_case(list, 32'h0000_4000 + 32'(j * 64), 2'(c & 3), c[2], c[3], c[4],
                         (c + j) % 3);
            end
        end
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule